// File: doc/BRIEF.md
# Spread-Spectrum Triangle Modulation Generator

This block drives the fractional part of a feedback divider so that the synthesized clock sweeps its frequency along a linear triangle. It produces a signed offset word and a one-cycle strobe each time a new offset is issued. The offset is in units of 2^-16 of the nominal divide ratio. The analog loop and the fractional divider that consumes the word lie outside the block.

Two profile shapes are available. The centred shape deviates equally above and below nominal, so its average offset is zero. The downward shape has its highest point exactly at nominal, with every other point below it. A rate input picks one of two sweep frequencies: a slow one near 31 kHz, suited to loads that carry their own PLL, and a fast one near 120 kHz. The reference frequency, the number of steps in a half sweep and the amplitude quantum are parameters. From them the block derives how many reference cycles each step lasts.

A configuration change never causes a jump. Mode, amplitude and rate are taken only when a new modulation period begins, and every sweep begins at the lowest point of the profile.

Top module: `ssc_tri_gen`

## Requirements
- R1: While `rst_i` is high, and on the cycle after it has been sampled high, `ofs_o` is 0 and `stb_o` is 0.
- R2: While `en_i` is sampled low, `ofs_o` is forced to 0 from the next cycle and `stb_o` stays 0. Changes on `down_i`, `fast_i` and `amp_i` in this state have no visible effect.
- R3: When `en_i` is first sampled high, `stb_o` pulses in the very next cycle and `ofs_o` carries the minimum of the profile selected by the inputs at that edge. Position 0 is the start of a period.
- R4: The profile runs through positions p = 0..31, with k = p for p <= 16 and k = 32 - p otherwise. The offset at position p is lo + k*s. Here A = (amp_i+1)*80, s = 2A/16 and lo is the shape minimum. One period therefore rises from minimum to maximum in 16 equal steps and falls back in 16.
- R5: In centred mode (`down_i` = 0), lo = -A and the maximum is +A, which gives ±0.122% to ±1.95% for codes 0..15. The offsets of one full period sum to exactly 0.
- R6: In downward mode (`down_i` = 1), lo = -2A, the maximum is exactly 0 and no offset is positive. The span never exceeds 2560 (3.9% of nominal), and the offsets of one full period sum to -32A.
- R7: With the default 25 MHz reference, strobes are 25 cycles apart when `fast_i` = 0 (a period of 800 cycles, 31.25 kHz). They are 6 cycles apart when `fast_i` = 1 (192 cycles, about 130 kHz).
- R8: Mode, amplitude and rate are sampled only at the strobe of position 0. Changes made at any other point of a period take effect at the start of the next period.
- R9: `stb_o` is a one-cycle pulse per step, and `ofs_o` changes only in a strobe cycle or when it is forced to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Reference clock |
| rst_i | input | 1 | Synchronous reset, active high |
| en_i | input | 1 | Run the sweep; low forces a zero offset |
| down_i | input | 1 | Profile shape: 0 centred, 1 downward |
| fast_i | input | 1 | Sweep rate: 0 slow (~31 kHz), 1 fast (~120 kHz) |
| amp_i | input | 4 | Amplitude code; peak deviation is (code+1) quanta |
| ofs_o | output | OFS_W (16) | Signed divider offset in 2^-16 units of nominal |
| stb_o | output | 1 | One-cycle pulse marking a new offset |

## Verification
The properties assume that every input is synchronous to the reference clock. They also assume that both step intervals are at least two cycles and that twice the amplitude quantum is a multiple of the step count, so the steps stay exact integers. The bench uses the default parameters, which give intervals of 25 and 6 cycles and a quantum of 80 over 16 steps. It changes inputs only on the falling edge, so each one is seen cleanly at a single sampling edge. Configuration is changed in the middle of a period on purpose, so that the deferred-latch property and the bench model are checked against live changes rather than against quiet inputs.

// File: rtl/ssc_pkg.sv
package ssc_pkg;

    localparam int CODE_W = 4;

    // Sweep configuration, taken as one unit at a period boundary
    typedef struct packed {
        logic              down;
        logic              fast;
        logic [CODE_W-1:0] code;
    } ssc_cfg_t;

endpackage

// File: rtl/ssc_pace.sv
// Step interval selection: reload value of the step countdown per rate.
module ssc_pace #(
    parameter int REF_HZ  = 25_000_000,
    parameter int SLOW_HZ = 31_250,
    parameter int FAST_HZ = 120_000,
    parameter int STEPS   = 16,
    parameter int CNT_W   = 5
) (
    input  logic             fast_i,
    output logic [CNT_W-1:0] reload_o
);
    localparam int SLOW_I = REF_HZ / (SLOW_HZ * 2 * STEPS);
    localparam int FAST_I = REF_HZ / (FAST_HZ * 2 * STEPS);

    always_comb begin
        if (fast_i) reload_o = CNT_W'(FAST_I - 1);
        else        reload_o = CNT_W'(SLOW_I - 1);
    end
endmodule

// File: rtl/ssc_shape.sv
// Maps a period position and configuration to the signed offset.
module ssc_shape
    import ssc_pkg::*;
#(
    parameter int STEPS_LOG2 = 4,
    parameter int AMP_UNIT   = 80,
    parameter int OFS_W      = 16,
    parameter int POS_W      = STEPS_LOG2 + 1
) (
    input  ssc_cfg_t                cfg_i,
    input  logic [POS_W-1:0]        pos_i,
    output logic signed [OFS_W-1:0] ofs_o
);
    localparam int STEPS = 1 << STEPS_LOG2;

    int amp;
    int span;
    int stp;
    int k;
    int lo;

    always_comb begin
        amp  = (int'(cfg_i.code) + 1) * AMP_UNIT;
        span = 2 * amp;
        stp  = span / STEPS;
        if (int'(pos_i) <= STEPS) k = int'(pos_i);
        else                      k = 2 * STEPS - int'(pos_i);
        lo    = cfg_i.down ? -span : -amp;
        ofs_o = OFS_W'(lo + k * stp);
    end
endmodule

// File: rtl/ssc_tri_gen.sv
// Triangle sweep generator for a fractional feedback divider.
module ssc_tri_gen
    import ssc_pkg::*;
#(
    parameter int REF_HZ     = 25_000_000,
    parameter int SLOW_HZ    = 31_250,
    parameter int FAST_HZ    = 120_000,
    parameter int STEPS_LOG2 = 4,
    parameter int AMP_UNIT   = 80,
    parameter int OFS_W      = 16
) (
    input  logic                    clk_i,
    input  logic                    rst_i,
    input  logic                    en_i,
    input  logic                    down_i,
    input  logic                    fast_i,
    input  logic [CODE_W-1:0]       amp_i,
    output logic signed [OFS_W-1:0] ofs_o,
    output logic                    stb_o
);
    localparam int STEPS  = 1 << STEPS_LOG2;
    localparam int POS_W  = STEPS_LOG2 + 1;
    localparam int LAST   = 2 * STEPS - 1;
    localparam int SLOW_I = REF_HZ / (SLOW_HZ * 2 * STEPS);
    localparam int CNT_W  = $clog2(SLOW_I + 1);

    typedef struct packed {
        logic                    run;
        logic [CNT_W-1:0]        cnt;
        logic [POS_W-1:0]        pos;
        ssc_cfg_t                cfg;
        logic signed [OFS_W-1:0] ofs;
        logic                    stb;
    } state_t;

    state_t st_q, st_d;

    ssc_cfg_t                cfg_in;
    ssc_cfg_t                cfg_use;
    logic [POS_W-1:0]        pos_use;
    logic                    emit;
    logic signed [OFS_W-1:0] shape_ofs;
    logic [CNT_W-1:0]        reload;

    // Step decision and the configuration/position it applies to
    always_comb begin
        cfg_in  = '{down: down_i, fast: fast_i, code: amp_i};
        emit    = en_i && (!st_q.run || st_q.cnt == '0);
        pos_use = st_q.run ? st_q.pos : '0;
        cfg_use = (!st_q.run || st_q.pos == '0) ? cfg_in : st_q.cfg;
    end

    ssc_shape #(
        .STEPS_LOG2(STEPS_LOG2),
        .AMP_UNIT  (AMP_UNIT),
        .OFS_W     (OFS_W),
        .POS_W     (POS_W)
    ) u_shape (
        .cfg_i(cfg_use),
        .pos_i(pos_use),
        .ofs_o(shape_ofs)
    );

    ssc_pace #(
        .REF_HZ (REF_HZ),
        .SLOW_HZ(SLOW_HZ),
        .FAST_HZ(FAST_HZ),
        .STEPS  (STEPS),
        .CNT_W  (CNT_W)
    ) u_pace (
        .fast_i  (cfg_use.fast),
        .reload_o(reload)
    );

    always_comb begin
        st_d     = st_q;
        st_d.stb = 1'b0;
        if (!en_i) begin
            st_d.run = 1'b0;
            st_d.cnt = '0;
            st_d.pos = '0;
            st_d.ofs = '0;
        end else if (emit) begin
            st_d.run = 1'b1;
            st_d.cfg = cfg_use;
            st_d.ofs = shape_ofs;
            st_d.stb = 1'b1;
            st_d.cnt = reload;
            if (pos_use == POS_W'(LAST)) st_d.pos = '0;
            else                         st_d.pos = pos_use + 1'b1;
        end else begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) st_q <= '0;
        else       st_q <= st_d;
    end

    assign ofs_o = st_q.ofs;
    assign stb_o = st_q.stb;
endmodule

// File: rtl/ssc_tri_gen_chk.sv
// Temporal checks on the triangle generator, attached by bind.
module ssc_tri_gen_chk #(
    parameter int OFS_W    = 16,
    parameter int CODE_W   = 4,
    parameter int AMP_UNIT = 80
) (
    input logic                    clk_i,
    input logic                    rst_i,
    input logic                    en_i,
    input logic signed [OFS_W-1:0] ofs_i,
    input logic                    stb_i,
    input logic                    lat_down_i,
    input logic [CODE_W-1:0]       lat_code_i
);
    localparam int AW = OFS_W + 1;

    logic signed [AW-1:0] amp_lim;
    assign amp_lim = AW'((int'(lat_code_i) + 1) * AMP_UNIT);

    a_r2_idle_zero: assert property (@(posedge clk_i) disable iff (rst_i)
        !en_i |=> (ofs_i == '0 && !stb_i));

    a_r3_start_strobe: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(en_i) |=> stb_i);

    a_r9_single_pulse: assert property (@(posedge clk_i) disable iff (rst_i)
        stb_i |=> !stb_i);

    a_r9_hold_between: assert property (@(posedge clk_i) disable iff (rst_i)
        (!stb_i && $past(en_i)) |-> $stable(ofs_i));

    a_r6_down_nonpos: assert property (@(posedge clk_i) disable iff (rst_i)
        (stb_i && lat_down_i) |-> ofs_i <= 0);

    a_r5_center_bound: assert property (@(posedge clk_i) disable iff (rst_i)
        (stb_i && !lat_down_i) |-> (ofs_i <= amp_lim && ofs_i >= -amp_lim));
endmodule

bind ssc_tri_gen ssc_tri_gen_chk #(
    .OFS_W   (OFS_W),
    .CODE_W  (ssc_pkg::CODE_W),
    .AMP_UNIT(AMP_UNIT)
) u_chk (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .en_i      (en_i),
    .ofs_i     (ofs_o),
    .stb_i     (stb_o),
    .lat_down_i(st_q.cfg.down),
    .lat_code_i(st_q.cfg.code)
);

// File: tb/ssc_tri_gen_test.sv
module ssc_tri_gen_test;
    logic               clk = 1'b0;
    logic               rst;
    logic               en;
    logic               down;
    logic               fast;
    logic [3:0]         amp;
    logic signed [15:0] ofs;
    logic               stb;

    always #2.5 clk = ~clk;

    ssc_tri_gen uut (
        .clk_i (clk),
        .rst_i (rst),
        .en_i  (en),
        .down_i(down),
        .fast_i(fast),
        .amp_i (amp),
        .ofs_o (ofs),
        .stb_o (stb)
    );

    // {down, fast, code, expected minimum, expected maximum}
    localparam logic [37:0] VEC [6] = '{
        {1'b0, 1'b0, 4'd0,  -16'sd80,   16'sd80},
        {1'b0, 1'b1, 4'd15, -16'sd1280, 16'sd1280},
        {1'b1, 1'b0, 4'd15, -16'sd2560, 16'sd0},
        {1'b1, 1'b1, 4'd0,  -16'sd160,  16'sd0},
        {1'b0, 1'b1, 4'd7,  -16'sd640,  16'sd640},
        {1'b1, 1'b0, 4'd4,  -16'sd800,  16'sd0}
    };

    int checks = 0;
    int errors = 0;
    int cyc    = 0;
    int m_pos, m_down, m_fast, m_code, m_gap_exp, gap, nstb;
    int psum, vmin, vmax;
    bit pfull;
    logic signed [15:0] last_ofs;
    string cur_tag = "R4 offset value";

    function automatic int exp_val(int d, int c, int p);
        int a = (c + 1) * 80;
        int s = 2 * a / 16;
        int k = (p <= 16) ? p : 32 - p;
        return (d != 0 ? -2 * a : -a) + k * s;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic idle_check(input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            chk(ofs == 0 && !stb, tag, int'(ofs) + (stb ? 100000 : 0), 0);
        end
        last_ofs = '0;
    endtask

    task automatic start();
        en = 1'b1; m_pos = 0; m_gap_exp = 1; gap = 0;
        psum = 0; pfull = 0; vmin = 32767; vmax = -32768;
    endtask

    task automatic step_watch();
        int e;
        @(negedge clk);
        gap++;
        if (stb) begin
            chk(gap == m_gap_exp, m_gap_exp == 1 ? "R3 start latency" : "R7 step spacing",
                gap, m_gap_exp);
            if (m_pos == 0) begin
                m_down = down; m_fast = fast; m_code = amp; psum = 0; pfull = 1;
            end
            e = exp_val(m_down, m_code, m_pos);
            chk(ofs == e, cur_tag, int'(ofs), e);
            if (m_down != 0) chk(ofs <= 0, "R6 never above nominal", int'(ofs), 0);
            psum += int'(ofs);
            if (int'(ofs) < vmin) vmin = int'(ofs);
            if (int'(ofs) > vmax) vmax = int'(ofs);
            m_gap_exp = (m_fast != 0) ? 6 : 25;
            gap = 0;
            nstb++;
            if (m_pos == 31) begin
                if (pfull) begin
                    if (m_down != 0) chk(psum == -32 * (m_code + 1) * 80, "R6 period sum",
                                         psum, -32 * (m_code + 1) * 80);
                    else chk(psum == 0, "R5 period sum", psum, 0);
                end
                m_pos = 0;
            end else begin
                m_pos++;
            end
        end else begin
            chk(ofs == last_ofs, "R9 hold between steps", int'(ofs), int'(last_ofs));
        end
        last_ofs = ofs;
    endtask

    task automatic watch_strobes(input int n);
        int n0 = nstb;
        while (nstb - n0 < n) step_watch();
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                errors++;
                $display("FAIL watchdog all requirements actual %0d expected %0d", cyc, 150000);
                $display("CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        nstb = 0;
        rst = 1'b1; en = 1'b0; down = 1'b0; fast = 1'b0; amp = 4'd0;
        repeat (3) @(negedge clk);
        chk(ofs == 0 && !stb, "R1 reset state", int'(ofs), 0);
        rst = 1'b0;

        // R2: configuration toggles while disabled
        down = 1'b1; fast = 1'b1; amp = 4'd12;
        idle_check(8, "R2 disabled output zero");

        // Table walk: one full period plus the return to minimum
        foreach (VEC[i]) begin
            en = 1'b0;
            idle_check(3, "R2 disabled output zero");
            down = VEC[i][37]; fast = VEC[i][36]; amp = VEC[i][35:32];
            start();
            watch_strobes(33);
            chk(vmin == int'($signed(VEC[i][31:16])),
                VEC[i][37] ? "R6 profile minimum" : "R5 profile minimum",
                vmin, int'($signed(VEC[i][31:16])));
            chk(vmax == int'($signed(VEC[i][15:0])),
                VEC[i][37] ? "R6 profile maximum" : "R5 profile maximum",
                vmax, int'($signed(VEC[i][15:0])));
        end

        // R8: change everything mid-period; old values must finish the period
        en = 1'b0;
        idle_check(2, "R2 disabled output zero");
        down = 1'b0; fast = 1'b0; amp = 4'd3;
        start();
        watch_strobes(6);
        cur_tag = "R8 latched config";
        down = 1'b1; fast = 1'b1; amp = 4'd9;
        watch_strobes(40);
        cur_tag = "R4 offset value";

        // R2/R3: drop enable mid-sweep, then restart at the minimum
        watch_strobes(5);
        en = 1'b0;
        idle_check(2, "R2 disabled mid-sweep");
        down = 1'b0; fast = 1'b1; amp = 4'd5;
        cur_tag = "R3 restart at minimum";
        start();
        watch_strobes(1);
        cur_tag = "R4 offset value";
        watch_strobes(3);

        // R1: reset while running
        rst = 1'b1;
        @(negedge clk);
        chk(ofs == 0 && !stb, "R1 reset while running", int'(ofs), 0);
        en = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        idle_check(2, "R2 disabled output zero");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule